// File: doc/BRIEF.md
# Validity-Qualified Content-Addressable Compare Engine

This block holds a small table of stored words and compares a comparand register against every entry at once. Each entry carries a two-bit validity state, and only entries whose state equals the requested condition can produce a hit. Two mask registers are available. The control register selects which mask, if any, applies to a compare. A mask bit of 1 removes that bit position from the comparison. The results are a match flag, a multiple-match flag and the index of the lowest-numbered hit. These results are registered and hold until the next compare.

A compare can start in two ways. A forced compare is an explicit command that carries a validity condition. An automatic compare is queued by certain register updates and always looks for Valid entries only. Two updates queue it: a control-register write that is not a soft reset, and a comparand or mask write made while the segment end-limit pulse is high. An automatic compare runs in the cycle after its trigger, so it uses the freshly written settings. A forced compare against Empty ignores every data bit.

If a forced compare and a queued automatic compare fall in the same cycle, the forced compare's condition is used and the queued request is consumed.

Top module: `cam_cmp_engine`

## Requirements
- R1: A forced compare (`cmp_go`=1) is evaluated against all entries in the cycle it is sampled. Its result appears on the outputs after that same clock edge.
- R2: Mask register writes use `reg_sel`: 1 writes mask A and 2 writes mask B. The mask applied to a compare comes from control bits [1:0]: 0 means no mask, 1 means mask A, 2 means mask B, and 3 means the OR of both. A mask bit of 1 excludes that data bit from the compare.
- R3: An automatic compare matches only Valid entries. It executes one cycle after its trigger, so its result appears after the second clock edge following the write.
- R4: A write to the comparand (`reg_sel`=0) or to either mask queues an automatic compare when `seg_end` is 1. The same write with `seg_end`=0 queues nothing.
- R5: A control write queues an automatic compare unless bit 2 (soft reset) is set. A soft-reset write clears the mask selection to 0 and starts no compare.
- R6: A forced compare matches only entries whose state equals `cmp_cond`. The encodings are Empty=0, Valid=1, Skip=2 and Random=3.
- R7: A forced compare with condition Empty ignores all data bits, so every Empty entry matches.
- R8: `match_addr` is the lowest matching index, or 0 when nothing matches. `multi_flag` is 1 exactly when two or more entries match.
- R9: The three outputs keep their values in every cycle in which no compare executes.
- R10: Reset sets every entry to Empty, clears all registers and drives all outputs to 0.
- R11: `wr_entry` stores `wr_data` and `wr_state` at entry `wr_addr`. A compare in the same cycle sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_entry | input | 1 | Entry write strobe |
| wr_addr | input | AW | Entry index to write |
| wr_data | input | W | Entry data word |
| wr_state | input | 2 | Entry validity state |
| wr_reg | input | 1 | Comparand/mask write strobe |
| reg_sel | input | 2 | 0 comparand, 1 mask A, 2 mask B |
| reg_data | input | W | Register write data |
| seg_end | input | 1 | Segment end-limit pulse with a register write |
| wr_ctrl | input | 1 | Control write strobe |
| ctrl_data | input | 3 | [1:0] mask select, [2] soft reset |
| cmp_go | input | 1 | Forced compare command |
| cmp_cond | input | 2 | Validity condition of a forced compare |
| match_flag | output | 1 | At least one entry matched |
| multi_flag | output | 1 | Two or more entries matched |
| match_addr | output | AW | Lowest matching index |

## Verification
A wrong validity state or a stale stored word shows up at the next compare that targets that entry's condition, as a missing hit or an extra hit. Both change `match_flag`, `multi_flag` or `match_addr` one edge after the compare executes. A lost or spurious automatic trigger is harder to see. It shows only as outputs that fail to change, or that change, two edges after the write. The bench therefore checks the cycle after the trigger as well as the cycle after the compare. A corrupted mask selection shows only under comparands chosen so that the masked and unmasked results differ.

// File: rtl/cam_eng_pkg.sv
package cam_eng_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY  = 2'b00,
    ST_VALID  = 2'b01,
    ST_SKIP   = 2'b10,
    ST_RANDOM = 2'b11
  } vstate_e;

  localparam logic [1:0] SEL_CMPD  = 2'd0;
  localparam logic [1:0] SEL_MASKA = 2'd1;
  localparam logic [1:0] SEL_MASKB = 2'd2;

  localparam int unsigned CTRL_SOFT_RST = 2;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int unsigned W  = 64,
  parameter int unsigned D  = 16,
  parameter int unsigned AW = $clog2(D)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [W-1:0]        wdata,
  input  logic [1:0]          wstate,
  output logic [D-1:0][W-1:0] words,
  output logic [D-1:0][1:0]   states
);
  for (genvar i = 0; i < D; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[i]  <= '0;
        states[i] <= cam_eng_pkg::ST_EMPTY;
      end else if (we && waddr == AW'(i)) begin
        words[i]  <= wdata;
        states[i] <= wstate;
      end
    end
  end
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
  parameter int unsigned W = 64,
  parameter int unsigned D = 16
) (
  input  logic [D-1:0][W-1:0] words,
  input  logic [D-1:0][1:0]   states,
  input  logic [W-1:0]        key,
  input  logic [W-1:0]        mask,
  input  logic [1:0]          cond,
  output logic [D-1:0]        hits
);
  function automatic logic masked_equal(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic [W-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  for (genvar i = 0; i < D; i++) begin : g_cmp
    assign hits[i] = (states[i] == cond) && masked_equal(words[i], key, mask);
  end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int unsigned D  = 16,
  parameter int unsigned AW = $clog2(D)
) (
  input  logic [D-1:0]  hits,
  output logic          any,
  output logic          multi,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] lowest_set(input logic [D-1:0] v);
    logic [AW-1:0] r;
    r = '0;
    for (int i = D - 1; i >= 0; i--) begin
      if (v[i]) r = AW'(i);
    end
    return r;
  endfunction

  function automatic logic two_or_more(input logic [D-1:0] v);
    logic seen;
    logic dup;
    seen = 1'b0;
    dup  = 1'b0;
    for (int i = 0; i < D; i++) begin
      if (v[i] && seen) dup = 1'b1;
      if (v[i]) seen = 1'b1;
    end
    return dup;
  endfunction

  assign any   = |hits;
  assign multi = two_or_more(hits);
  assign addr  = lowest_set(hits);
endmodule

// File: rtl/cam_cmp_engine.sv
module cam_cmp_engine #(
  parameter int unsigned W  = 64,
  parameter int unsigned D  = 16,
  parameter int unsigned AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_entry,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [1:0]    wr_state,
  input  logic          wr_reg,
  input  logic [1:0]    reg_sel,
  input  logic [W-1:0]  reg_data,
  input  logic          seg_end,
  input  logic          wr_ctrl,
  input  logic [2:0]    ctrl_data,
  input  logic          cmp_go,
  input  logic [1:0]    cmp_cond,
  output logic          match_flag,
  output logic          multi_flag,
  output logic [AW-1:0] match_addr
);
  import cam_eng_pkg::*;

  logic [W-1:0]        comparand;
  logic [W-1:0]        mask_a;
  logic [W-1:0]        mask_b;
  logic [1:0]          mask_sel;
  logic                auto_pend;
  logic                auto_trig;
  logic                cmp_fire;
  logic [1:0]          eff_cond;
  logic [W-1:0]        eff_mask;
  logic [D-1:0][W-1:0] words;
  logic [D-1:0][1:0]   states;
  logic [D-1:0]        hits;
  logic                hit_any;
  logic                hit_multi;
  logic [AW-1:0]       hit_addr;

  function automatic logic [W-1:0] pick_mask(input logic [1:0] sel,
                                             input logic [W-1:0] ma,
                                             input logic [W-1:0] mb);
    logic [W-1:0] r;
    r = '0;
    if (sel[0]) r = r | ma;
    if (sel[1]) r = r | mb;
    return r;
  endfunction

  assign auto_trig = (wr_ctrl && !ctrl_data[CTRL_SOFT_RST]) ||
                     (wr_reg && seg_end);
  assign cmp_fire  = cmp_go || auto_pend;
  assign eff_cond  = cmp_go ? cmp_cond : ST_VALID;
  assign eff_mask  = (cmp_go && cmp_cond == ST_EMPTY) ? '1
                   : pick_mask(mask_sel, mask_a, mask_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comparand <= '0;
      mask_a    <= '0;
      mask_b    <= '0;
      mask_sel  <= '0;
      auto_pend <= 1'b0;
    end else begin
      auto_pend <= auto_trig;
      if (wr_reg) begin
        case (reg_sel)
          SEL_CMPD:  comparand <= reg_data;
          SEL_MASKA: mask_a    <= reg_data;
          SEL_MASKB: mask_b    <= reg_data;
          default:   ;
        endcase
      end
      if (wr_ctrl) begin
        mask_sel <= ctrl_data[CTRL_SOFT_RST] ? 2'b00 : ctrl_data[1:0];
      end
    end
  end

  cam_store #(.W(W), .D(D), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_entry), .waddr(wr_addr),
    .wdata(wr_data), .wstate(wr_state), .words(words), .states(states)
  );

  cam_match_array #(.W(W), .D(D)) u_match (
    .words(words), .states(states), .key(comparand), .mask(eff_mask),
    .cond(eff_cond), .hits(hits)
  );

  cam_prio_enc #(.D(D), .AW(AW)) u_prio (
    .hits(hits), .any(hit_any), .multi(hit_multi), .addr(hit_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      multi_flag <= 1'b0;
      match_addr <= '0;
    end else if (cmp_fire) begin
      match_flag <= hit_any;
      multi_flag <= hit_multi;
      match_addr <= hit_addr;
    end
  end
endmodule

// File: rtl/cam_eng_chk.sv
module cam_eng_chk #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_reg,
  input logic          seg_end,
  input logic          wr_ctrl,
  input logic [2:0]    ctrl_data,
  input logic          cmp_go,
  input logic          cmp_fire,
  input logic          auto_pend,
  input logic          hit_any,
  input logic          match_flag,
  input logic          multi_flag,
  input logic [AW-1:0] match_addr
);
  p_multi_needs_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    multi_flag |-> match_flag);

  p_idle_addr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !match_flag |-> match_addr == '0);

  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> $stable({match_flag, multi_flag, match_addr}));

  p_seg_end_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && seg_end) |=> cmp_fire);

  p_ctrl_auto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !ctrl_data[2]) |=> cmp_fire);

  p_soft_rst_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_data[2] && !(wr_reg && seg_end)) |=> !auto_pend);

  p_result_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> match_flag == $past(hit_any));

  p_forced_fires_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |-> cmp_fire);
endmodule

bind cam_cmp_engine cam_eng_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_reg(wr_reg), .seg_end(seg_end),
  .wr_ctrl(wr_ctrl), .ctrl_data(ctrl_data), .cmp_go(cmp_go),
  .cmp_fire(cmp_fire), .auto_pend(auto_pend), .hit_any(hit_any),
  .match_flag(match_flag), .multi_flag(multi_flag), .match_addr(match_addr)
);

// File: tb/cam_cmp_engine_test.sv
module cam_cmp_engine_test;
  localparam int unsigned W  = 64;
  localparam int unsigned D  = 16;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_entry = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [1:0]    wr_state = '0;
  logic          wr_reg = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [W-1:0]  reg_data = '0;
  logic          seg_end = 1'b0;
  logic          wr_ctrl = 1'b0;
  logic [2:0]    ctrl_data = '0;
  logic          cmp_go = 1'b0;
  logic [1:0]    cmp_cond = '0;
  logic          match_flag;
  logic          multi_flag;
  logic [AW-1:0] match_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cam_cmp_engine #(.W(W), .D(D), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_entry(wr_entry), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_state(wr_state), .wr_reg(wr_reg),
    .reg_sel(reg_sel), .reg_data(reg_data), .seg_end(seg_end),
    .wr_ctrl(wr_ctrl), .ctrl_data(ctrl_data), .cmp_go(cmp_go),
    .cmp_cond(cmp_cond), .match_flag(match_flag), .multi_flag(multi_flag),
    .match_addr(match_addr)
  );

  // Validity codes: Empty 0, Valid 1, Skip 2, Random 3
  // Row: [73:72] cond, [71:8] comparand, [7:6] mask select,
  //      [5] match, [4] multi, [3:0] addr
  localparam int NROW = 9;
  localparam logic [73:0] TBL [NROW] = '{
    {2'd1, 64'h2222, 2'd0, 1'b1, 1'b1, 4'd1},  // R8 duplicates, lowest wins
    {2'd1, 64'h1111, 2'd0, 1'b1, 1'b0, 4'd0},  // R6 single valid
    {2'd2, 64'h2222, 2'd0, 1'b1, 1'b0, 4'd2},  // R6 skip only
    {2'd3, 64'h3333, 2'd0, 1'b1, 1'b0, 4'd3},  // R6 random only
    {2'd3, 64'h2222, 2'd0, 1'b0, 1'b0, 4'd0},  // R6 wrong state no hit
    {2'd0, 64'h1234, 2'd0, 1'b1, 1'b1, 4'd6},  // R7 empty ignores data
    {2'd1, 64'h00FF, 2'd1, 1'b1, 1'b0, 4'd5},  // R2 mask A low byte
    {2'd1, 64'h0002, 2'd2, 1'b1, 1'b1, 4'd1},  // R2 mask B nibble only
    {2'd1, 64'h9999, 2'd0, 1'b0, 1'b0, 4'd0}   // R8 none -> addr 0
  };

  task automatic finish_up();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic check_out(input string req, input logic em, input logic emu,
                           input logic [AW-1:0] ea);
    n_chk++;
    if (match_flag !== em || multi_flag !== emu || match_addr !== ea) begin
      n_bad++;
      $display("FAIL %s: got m=%0b mm=%0b a=%0d expected m=%0b mm=%0b a=%0d",
               req, match_flag, multi_flag, match_addr, em, emu, ea);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_entry(input int a, input logic [W-1:0] d, input logic [1:0] s);
    wr_entry = 1'b1; wr_addr = AW'(a); wr_data = d; wr_state = s;
    edges(1);
    wr_entry = 1'b0;
  endtask

  task automatic put_reg(input logic [1:0] sel, input logic [W-1:0] d, input logic se);
    wr_reg = 1'b1; reg_sel = sel; reg_data = d; seg_end = se;
    edges(1);
    wr_reg = 1'b0; seg_end = 1'b0;
  endtask

  task automatic put_ctrl(input logic [2:0] c);
    wr_ctrl = 1'b1; ctrl_data = c;
    edges(1);
    wr_ctrl = 1'b0;
  endtask

  task automatic forced(input logic [1:0] c);
    cmp_go = 1'b1; cmp_cond = c;
    edges(1);
    cmp_go = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    edges(3);
    check_out("R10 reset outputs", 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    edges(1);
    forced(2'd0);
    check_out("R10 all empty after reset (R7)", 1'b1, 1'b1, 4'd0);

    put_entry(0, 64'h1111, 2'd1);
    put_entry(1, 64'h2222, 2'd1);
    put_entry(2, 64'h2222, 2'd2);
    put_entry(3, 64'h3333, 2'd3);
    put_entry(4, 64'h2222, 2'd1);
    put_entry(5, 64'h00AB, 2'd1);
    put_reg(2'd1, 64'hFF, 1'b0);
    put_reg(2'd2, ~64'hF, 1'b0);

    for (int r = 0; r < NROW; r++) begin
      put_reg(2'd0, TBL[r][71:8], 1'b0);
      put_ctrl({1'b0, TBL[r][7:6]});
      edges(2);
      forced(TBL[r][73:72]);
      check_out($sformatf("R1 R11 table row %0d", r),
                TBL[r][5], TBL[r][4], TBL[r][3:0]);
    end

    // R11: compare in the same cycle as an entry write sees old contents
    put_reg(2'd0, 64'h7777, 1'b0);
    wr_entry = 1'b1; wr_addr = 4'd7; wr_data = 64'h7777; wr_state = 2'd1;
    cmp_go = 1'b1; cmp_cond = 2'd1;
    edges(1);
    wr_entry = 1'b0; cmp_go = 1'b0;
    check_out("R11 same-cycle write unseen", 1'b0, 1'b0, 4'd0);
    forced(2'd1);
    check_out("R11 written entry found", 1'b1, 1'b0, 4'd7);

    // R4 / R3: comparand write with end-limit -> auto compare two edges on
    put_reg(2'd0, 64'h00AB, 1'b1);
    check_out("R3 not yet compared", 1'b1, 1'b0, 4'd7);
    edges(1);
    check_out("R4 auto on seg_end", 1'b1, 1'b0, 4'd5);

    // R9 / R4: no seg_end -> nothing changes
    put_reg(2'd0, 64'h1111, 1'b0);
    edges(3);
    check_out("R9 R4 hold without trigger", 1'b1, 1'b0, 4'd5);

    // R5: control write triggers auto compare
    put_ctrl(3'b000);
    edges(1);
    check_out("R5 auto on ctrl write", 1'b1, 1'b0, 4'd0);

    // R3: auto compare matches Valid only, skip entry 2 ignored
    put_reg(2'd0, 64'h2222, 1'b0);
    put_reg(2'd1, 64'hFF, 1'b1);
    edges(1);
    check_out("R3 auto skips Skip state (R4 mask write)", 1'b1, 1'b1, 4'd1);

    // R3: Random entry never found by auto compare
    put_reg(2'd0, 64'h3333, 1'b1);
    edges(1);
    check_out("R3 auto skips Random state", 1'b0, 1'b0, 4'd0);

    // R5: soft reset starts no compare and clears mask select
    put_reg(2'd0, 64'h00FF, 1'b0);
    put_ctrl(3'b001);
    edges(1);
    check_out("R5 R2 auto with mask A", 1'b1, 1'b0, 4'd5);
    put_reg(2'd0, 64'h1111, 1'b0);
    put_ctrl(3'b101);
    edges(3);
    check_out("R5 soft reset no compare", 1'b1, 1'b0, 4'd5);
    put_reg(2'd0, 64'h00FF, 1'b0);
    forced(2'd1);
    check_out("R5 soft reset cleared mask select", 1'b0, 1'b0, 4'd0);

    // R2: select 3 ORs both masks (low byte ignored, high bits too)
    put_reg(2'd0, 64'hFFFF_FFFF_FFFF_FF05, 1'b0);
    put_ctrl(3'b011);
    edges(2);
    forced(2'd1);
    check_out("R2 both masks ORed", 1'b1, 1'b1, 4'd0);

    // R10: reset in mid-run clears entries and outputs
    rst_n = 1'b0;
    edges(2);
    check_out("R10 reset clears outputs", 1'b0, 1'b0, 4'd0);
    rst_n = 1'b1;
    put_reg(2'd0, 64'h1111, 1'b0);
    forced(2'd1);
    check_out("R10 no Valid entries after reset", 1'b0, 1'b0, 4'd0);

    finish_up();
  end
endmodule